// File: doc/BRIEF.md
# Zone Report Majority Voter

This block sits in a power transmitter that serves a group of receiver nodes in one zone. Each node sends an energy-state report, and the block keeps the latest value from each node in a table. When the zone-evaluate strobe arrives, the block builds a consensus value from all stored reports. It then marks as suspect every node whose report is too far from that consensus.

A second test runs at the same time. The block counts the power requests that each node makes between two evaluations and compares that count with a per-node budget set at design time. A node that goes over its budget is marked suspect even when its report agrees with the zone.

Each node has a 2-bit power level that the transmitter uses to scale what it sends to that node. A suspect node loses one level at each evaluation. A node found clean gains one level back, until it reaches full power again.

Top module: `zone_vote`

## Requirements
- R1: After reset, every suspect flag is 0, every power level is 3, every stored report is 0, every request count is 0, and every budget equals DEF_BUDGET.
- R2: A report strobe writes rpt_value into the table entry selected by rpt_node at the clock edge. An evaluation in the same cycle uses the value that was stored before that write.
- R3: The consensus value is a bitwise majority over all NODES stored reports. Consensus bit k is 1 only when more than NODES/2 entries have bit k set; a tie gives 0.
- R4: At evaluation, a node is flagged when the absolute difference between its stored report and the consensus is greater than thr. A difference equal to thr does not flag the node.
- R5: Requests are counted per node over a window that closes at each evaluation. A node whose count is greater than its budget is flagged. A count equal to the budget does not flag the node. A request in the same cycle as the evaluation is counted in the next window. Counts saturate at their maximum value.
- R6: The suspect flags and power levels take their new values in the cycle after the evaluation strobe. They hold their values in every cycle without an evaluation.
- R7: At each evaluation, a flagged node's power level falls by one, and it stays at 0 once it reaches 0 (0 is minimum power).
- R8: At each evaluation, a clean node's power level rises by one, and it stays at 3 once it reaches 3 (3 is full power). Its suspect flag clears.
- R9: A budget strobe writes bud_value into the budget of node bud_node. This budget is used by every later evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Report strobe |
| rpt_node | input | ID_W | Node that sent the report |
| rpt_value | input | VAL_W | Reported energy state |
| req_valid | input | 1 | Power-request strobe |
| req_node | input | ID_W | Node that made the request |
| bud_we | input | 1 | Budget write strobe |
| bud_node | input | ID_W | Node whose budget is written |
| bud_value | input | CNT_W | New request budget |
| thr | input | VAL_W | Deviation threshold |
| eval | input | 1 | Zone-evaluate strobe |
| suspect | output | NODES | Per-node suspect flag |
| power_lvl | output | 2*NODES | Per-node power code; node i uses bits [2i+1:2i] |

## Verification
Writes to the report, budget and count tables take effect at the edge where they are sampled. The suspect flags and power levels that an evaluation produces appear at the edge where the strobe is sampled, so they are visible in the following cycle. The bench drives every input at the falling edge and samples the outputs 1 ns after the next rising edge. At that point it compares the outputs with a model that it stepped once for the same cycle. It also checks the cycles that carry no evaluation, which confirms that the outputs hold exactly then.

// File: rtl/zone_vote.sv
module zone_vote #(
  parameter int NODES      = 8,
  parameter int VAL_W      = 8,
  parameter int CNT_W      = 8,
  parameter int DEF_BUDGET = 4,
  localparam int ID_W      = $clog2(NODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rpt_valid,
  input  logic [ID_W-1:0]    rpt_node,
  input  logic [VAL_W-1:0]   rpt_value,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_node,
  input  logic               bud_we,
  input  logic [ID_W-1:0]    bud_node,
  input  logic [CNT_W-1:0]   bud_value,
  input  logic [VAL_W-1:0]   thr,
  input  logic               eval,
  output logic [NODES-1:0]   suspect,
  output logic [2*NODES-1:0] power_lvl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [VAL_W-1:0] val_q [NODES];
  logic [CNT_W-1:0] cnt_q [NODES];
  logic [CNT_W-1:0] bud_q [NODES];
  logic [VAL_W-1:0] cons;
  logic [NODES-1:0] flag;

  always_comb begin
    for (int b = 0; b < VAL_W; b++) begin
      int ones;
      ones = 0;
      for (int n = 0; n < NODES; n++) ones += int'(val_q[n][b]);
      cons[b] = (ones > NODES / 2);
    end
  end

  for (genvar i = 0; i < NODES; i++) begin : g_node
    logic [VAL_W-1:0] dev;
    logic             hit;
    assign dev     = (val_q[i] > cons) ? val_q[i] - cons : cons - val_q[i];
    assign hit     = req_valid && (req_node == ID_W'(i));
    assign flag[i] = (dev > thr) || (cnt_q[i] > bud_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[i]            <= '0;
        cnt_q[i]            <= '0;
        bud_q[i]            <= CNT_W'(DEF_BUDGET);
        suspect[i]          <= 1'b0;
        power_lvl[2*i +: 2] <= 2'd3;
      end else begin
        if (rpt_valid && rpt_node == ID_W'(i)) val_q[i] <= rpt_value;
        if (bud_we && bud_node == ID_W'(i))    bud_q[i] <= bud_value;
        if (eval)                              cnt_q[i] <= hit ? CNT_W'(1) : '0;
        else if (hit && cnt_q[i] != CNT_MAX)   cnt_q[i] <= cnt_q[i] + 1'b1;
        if (eval) begin
          suspect[i] <= flag[i];
          if (flag[i] && power_lvl[2*i +: 2] != 2'd0)
            power_lvl[2*i +: 2] <= power_lvl[2*i +: 2] - 2'd1;
          else if (!flag[i] && power_lvl[2*i +: 2] != 2'd3)
            power_lvl[2*i +: 2] <= power_lvl[2*i +: 2] + 2'd1;
        end
      end
    end
  end
endmodule

module zone_vote_chk #(
  parameter int NODES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eval,
  input logic [NODES-1:0]   suspect,
  input logic [2*NODES-1:0] power_lvl
);
  // R6
  hold_without_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(suspect) && $stable(power_lvl));

  for (genvar i = 0; i < NODES; i++) begin : g_chk
    // R7
    flagged_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspect[i] |-> power_lvl[2*i +: 2] != 2'd3);
    // R8
    clean_not_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !suspect[i] |-> power_lvl[2*i +: 2] != 2'd0);
    // R7
    flag_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eval ##1 suspect[i] |-> power_lvl[2*i +: 2] <= $past(power_lvl[2*i +: 2]));
    // R8
    clean_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eval ##1 !suspect[i] |-> power_lvl[2*i +: 2] >= $past(power_lvl[2*i +: 2]));
  end
endmodule

bind zone_vote zone_vote_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .eval(eval), .suspect(suspect), .power_lvl(power_lvl)
);

// File: tb/tb_zone_vote.sv
module tb_zone_vote;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic rpt_valid = 0, req_valid = 0, bud_we = 0, eval = 0;
  logic [2:0] rpt_node = 0, req_node = 0, bud_node = 0;
  logic [7:0] rpt_value = 0, bud_value = 0, thr = 0;
  logic [N-1:0] suspect;
  logic [2*N-1:0] power_lvl;

  int checks = 0, errors = 0;
  int tbl[N], cnt[N], bud[N], lvl[N];
  logic [N-1:0] sus;

  zone_vote dut (.clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_node(rpt_node),
    .rpt_value(rpt_value), .req_valid(req_valid), .req_node(req_node), .bud_we(bud_we),
    .bud_node(bud_node), .bud_value(bud_value), .thr(thr), .eval(eval),
    .suspect(suspect), .power_lvl(power_lvl));

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int cons_of();
    int r = 0;
    for (int b = 0; b < 8; b++) begin
      int ones = 0;
      for (int n = 0; n < N; n++) ones += (tbl[n] >> b) & 1;
      if (ones > N / 2) r |= (1 << b);
    end
    return r;
  endfunction

  function automatic logic [2*N-1:0] lvl_vec();
    logic [2*N-1:0] v;
    for (int n = 0; n < N; n++) v[2*n +: 2] = 2'(lvl[n]);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, int rv, int rn, int rval, int qv, int qn, int ev,
                      int bw = 0, int bn = 0, int bval = 0);
    @(negedge clk);
    rpt_valid = rv[0]; rpt_node = 3'(rn); rpt_value = 8'(rval);
    req_valid = qv[0]; req_node = 3'(qn);
    bud_we = bw[0]; bud_node = 3'(bn); bud_value = 8'(bval);
    eval = ev[0];
    if (ev != 0) begin
      int c = cons_of();
      for (int n = 0; n < N; n++) begin
        int d = tbl[n] > c ? tbl[n] - c : c - tbl[n];
        logic f = (d > int'(thr)) || (cnt[n] > bud[n]);
        sus[n] = f;
        if (f && lvl[n] > 0) lvl[n]--;
        else if (!f && lvl[n] < 3) lvl[n]++;
      end
    end
    for (int n = 0; n < N; n++) begin
      logic h = (qv != 0) && (qn == n);
      if (ev != 0) cnt[n] = h ? 1 : 0;
      else if (h && cnt[n] < 255) cnt[n]++;
    end
    if (rv != 0) tbl[rn] = rval;
    if (bw != 0) bud[bn] = bval;
    @(posedge clk); #1;
    check({tag, " suspect"}, 32'(suspect), 32'(sus));
    check({tag, " power"}, 32'(power_lvl), 32'(lvl_vec()));
    rpt_valid = 0; req_valid = 0; bud_we = 0; eval = 0;
  endtask

  task automatic report_all(string tag, int base, int odd_node, int odd_val);
    for (int n = 0; n < N; n++) step(tag, 1, n, (n == odd_node) ? odd_val : base, 0, 0, 0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int n = 0; n < N; n++) begin tbl[n] = 0; cnt[n] = 0; bud[n] = 4; lvl[n] = 3; end
    sus = '0;
    thr = 8'd10;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 suspect", 32'(suspect), 32'h0);
    check("R1 power", 32'(power_lvl), 32'hffff);
    // R1 R5 default budget: 4 requests pass, 5 flag
    for (int k = 0; k < 4; k++) step("R5", 0, 0, 0, 1, 1, 0);
    step("R1 R5 count equal budget", 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 5; k++) step("R5", 0, 0, 0, 1, 1, 0);
    step("R5 over budget", 0, 0, 0, 1, 1, 1);
    step("R5 eval-cycle request in next window", 0, 0, 0, 0, 0, 1);
    // R9 raised budget
    step("R9 write", 0, 0, 0, 0, 0, 0, 1, 2, 7);
    for (int k = 0; k < 7; k++) step("R9", 0, 0, 0, 1, 2, 0);
    step("R9 within new budget", 0, 0, 0, 0, 0, 1);
    // R3 R4 threshold boundary
    report_all("R2", 100, 5, 110);
    step("R3 R4 diff equal thr", 0, 0, 0, 0, 0, 1);
    step("R2", 1, 5, 111, 0, 0, 0);
    step("R4 diff over thr", 0, 0, 0, 0, 0, 1);
    // R7 saturation at 0
    for (int k = 0; k < 4; k++) step("R7", 0, 0, 0, 0, 0, 1);
    // R2 same-cycle report and eval uses old value
    step("R2 same cycle", 1, 5, 100, 0, 0, 1);
    // R8 restore to 3
    for (int k = 0; k < 4; k++) step("R8", 0, 0, 0, 0, 0, 1);
    // R3 tie yields 0 bit
    for (int n = 0; n < N; n++) step("R3", 1, n, (n < 4) ? 8'h80 : 8'h00, 0, 0, 0);
    thr = 8'd0;
    step("R3 tie", 0, 0, 0, 0, 0, 1);
    // R6 hold without eval
    for (int k = 0; k < 5; k++) step("R6 hold", 1, k, 255, 1, k, 0);
    // random rounds
    for (int r = 0; r < 80; r++) begin
      int base = int'($urandom_range(40, 200));
      thr = 8'($urandom_range(0, 24));
      for (int n = 0; n < N; n++) begin
        int v = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 255))
                                              : base + int'($urandom_range(0, 6)) - 3;
        step("R2 R6 random", $urandom_range(0, 3) != 0, n, v,
             $urandom_range(0, 1), $urandom_range(0, N - 1), 0,
             $urandom_range(0, 9) == 0, $urandom_range(0, N - 1), $urandom_range(0, 6));
      end
      step("R3 R4 R5 R7 R8 random eval", 0, 0, 0, $urandom_range(0, 1), 0, 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule